// File: doc/BRIEF.md
# Load Latency Sampling Monitor

This block observes the memory operations that issue, retire or are cancelled in a core and measures the latency of one load at a time. A free-running 16-bit LFSR decides when the next load is picked for measurement: once its low three bits read zero while no load is being measured, the block arms. It then tags the next load that issues. A cycle counter runs from that load's issue until its retire. If the measured latency is strictly above a programmed threshold, the block counts the load and keeps its latency and a packed data-source word.

Software programs the threshold and the enable bits through a small write-only configuration port. A record writer sends a one-cycle assist request. One cycle later the block acknowledges and returns the latency and data-source word of the last qualifying tagged load that retired before the request. If the tagged load is cancelled, it leaves no trace, and the block re-arms at once so that the next issued load is tagged.

Top module: `load_latency_sampler`

## Requirements
- R1: Store operations are ignored: a store that issues is never tagged, and a store that retires never changes the count or the captured data.
- R2: A tagged load that retires is counted and captured only when its latency is strictly greater than the threshold. Each such load adds one to `qual_count`.
- R3: The threshold resets to 3. A configuration write with `cfg_sel`=0 loads `cfg_wdata[15:0]` into the threshold, and any value below 3 is raised to 3.
- R4: Tagging and counting run only while both enable bits are set. A write with `cfg_sel`=1 stores `cfg_wdata[0]` as the sampling enable and `cfg_wdata[32]` as the latency enable. Clearing either bit drops any tag in progress.
- R5: The LFSR resets to 16'hACE1 and shifts left every cycle. Its new bit 0 is the XOR of bits 15, 13, 12 and 10. In a cycle with no tag outstanding, the block arms if the LFSR's low 3 bits are zero or if it is already armed. Once armed, the first load issue tags that load.
- R6: Cancelling the tagged load clears the tag. The load is not counted, the captured data are kept, and the block arms so that the next load issue is tagged.
- R7: An assist request is answered with `asst_ack` high in the next cycle. The answer carries the values captured before the request cycle, so a load retiring in the request cycle itself is not included. The outputs hold their values between answers.
- R8: The data-source word packs the source code in bits 3:0, the second-level TLB miss flag in bit 4 and the locked-access flag in bit 5. Bits 63:6 read as zero.
- R9: Latency is the number of cycles from the issue edge to the retire edge, and it saturates at 65535.
- R10: After reset the count, the captured latency and source, and `asst_ack` are all zero, and both enables are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | A memory operation issues this cycle |
| iss_store | input | 1 | The issuing operation is a store |
| iss_id | input | 6 | Tracking id of the issuing operation |
| ret_valid | input | 1 | A memory operation retires this cycle |
| ret_store | input | 1 | The retiring operation is a store |
| ret_id | input | 6 | Tracking id of the retiring operation |
| ret_src | input | 4 | Data-source code of the retiring load |
| ret_stlb_miss | input | 1 | Retiring load missed the second-level TLB |
| ret_locked | input | 1 | Retiring load was part of a locked access |
| cxl_valid | input | 1 | A memory operation is cancelled this cycle |
| cxl_id | input | 6 | Tracking id of the cancelled operation |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the threshold, 1 selects the enable word |
| cfg_wdata | input | 64 | Configuration write data |
| asst_req | input | 1 | Assist request pulse |
| asst_ack | output | 1 | Assist answer valid, one cycle after the request |
| asst_lat | output | 16 | Captured latency returned to the assist |
| asst_src | output | 64 | Packed data-source word returned to the assist |
| qual_count | output | 32 | Number of qualifying tagged loads |

## Verification
Every result of this block appears one clock edge after the inputs that cause it. A qualifying retire at edge N shows in `qual_count` after edge N. A request sampled at edge N raises `asst_ack` after edge N, with the data held before that edge. A configuration write at edge N first takes effect at edge N+1. The bench drives all inputs at the falling edge. A behavioural model advances on the same rising edge as the design and is compared with every output at each falling edge. Directed checks read the captured values back through the assist port right after each retire or cancel.

// File: rtl/llsm_pkg.sv
// Package: shared types and helpers for the load latency sampling monitor.
// Assumes: the packed source word is 64 bits with six defined bits.
package llsm_pkg;

    localparam int SRC_WORD_W = 64;
    localparam int ATTR_W     = 6;

    // Attributes that a retiring load carries.
    typedef struct packed {
        logic       locked;
        logic       stlb_miss;
        logic [3:0] src;
    } ld_attr_t;

    // Configuration register selector.
    typedef enum logic {
        CFG_THRESH = 1'b0,
        CFG_ENABLE = 1'b1
    } cfg_sel_e;

    // Bit positions of the two enables inside the enable word.
    localparam int EN_SAMPLE_BIT  = 0;
    localparam int EN_LATENCY_BIT = 32;

    // Zero-extend the packed attributes into the source word.
    function automatic logic [SRC_WORD_W-1:0] pack_src(input ld_attr_t a);
        logic [SRC_WORD_W-1:0] w;
        w = '0;
        w[ATTR_W-1:0] = a;
        return w;
    endfunction

endpackage

// File: rtl/llsm_lfsr.sv
// Module: free-running Fibonacci LFSR that paces tag selection.
// Assumes: TAPS gives a maximal-length polynomial and SEED is nonzero.
module llsm_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);

    logic fb;

    // Feedback is the parity of the tapped bits.
    always_comb fb = ^(state & TAPS);

    // Shift left every cycle and insert the feedback bit.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= {state[W-2:0], fb};
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0); // R5

endmodule

// File: rtl/llsm_cfg.sv
// Module: configuration registers holding the latency threshold and the two enables.
// Assumes: writes take effect from the cycle after the strobe; only the low LAT_W bits of a threshold write are used.
module llsm_cfg
    import llsm_pkg::*;
#(
    parameter int LAT_W   = 16,
    parameter int DATA_W  = 64,
    parameter int THR_MIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [LAT_W-1:0]  thr,
    output logic              en
);

    localparam logic [LAT_W-1:0] THR_FLOOR = LAT_W'(THR_MIN);

    logic              en_sample;
    logic              en_latency;
    logic [LAT_W-1:0]  thr_wr;

    // Raise any requested threshold below the floor to the floor.
    always_comb begin
        thr_wr = cfg_wdata[LAT_W-1:0];
        if (thr_wr < THR_FLOOR) thr_wr = THR_FLOOR;
    end

    // Register writes by selector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr        <= THR_FLOOR;
            en_sample  <= 1'b0;
            en_latency <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_sel_e'(cfg_sel) == CFG_THRESH) begin
                thr <= thr_wr;
            end else begin
                en_sample  <= cfg_wdata[EN_SAMPLE_BIT];
                en_latency <= cfg_wdata[EN_LATENCY_BIT];
            end
        end
    end

    // Facility runs only with both enables set.
    always_comb en = en_sample && en_latency;

    AST_THR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        thr >= THR_FLOOR); // R3

endmodule

// File: rtl/llsm_tag_tracker.sv
// Module: picks one load at a time to measure and counts its latency.
// Assumes: ids of in-flight operations are unique. If a retire and a cancel
// hit the tagged id in the same cycle, the retire takes precedence.
module llsm_tag_tracker #(
    parameter int ID_W     = 6,
    parameter int LAT_W    = 16,
    parameter int SEL_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_BITS-1:0] lfsr_low,
    input  logic             iss_valid,
    input  logic             iss_store,
    input  logic [ID_W-1:0]  iss_id,
    input  logic             ret_valid,
    input  logic             ret_store,
    input  logic [ID_W-1:0]  ret_id,
    input  logic             cxl_valid,
    input  logic [ID_W-1:0]  cxl_id,
    output logic             ret_hit,
    output logic [LAT_W-1:0] ret_lat
);

    localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};

    logic            tag_v;
    logic            armed;
    logic [ID_W-1:0] tag_id;
    logic [LAT_W-1:0] lat;
    logic            pick_now;
    logic            take;
    logic            cxl_hit;

    // A tag may be taken when the LFSR window is open or the block is already armed.
    always_comb pick_now = armed || (lfsr_low == '0);

    // Tag the first load issued while nothing is tagged and the block is armed.
    always_comb take = iss_valid && !iss_store && !tag_v && pick_now;

    // Retire or cancel events that match the tagged load.
    always_comb begin
        ret_hit = en && tag_v && ret_valid && !ret_store && (ret_id == tag_id);
        cxl_hit = en && tag_v && cxl_valid && (cxl_id == tag_id) && !ret_hit;
    end

    // The latency seen at retire is the running count.
    always_comb ret_lat = lat;

    // Tag state machine and saturating latency counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_v  <= 1'b0;
            armed  <= 1'b0;
            tag_id <= '0;
            lat    <= '0;
        end else if (!en) begin
            tag_v <= 1'b0;
            armed <= 1'b0;
        end else if (take) begin
            tag_v  <= 1'b1;
            tag_id <= iss_id;
            lat    <= LAT_W'(1);
            armed  <= 1'b0;
        end else if (ret_hit) begin
            tag_v <= 1'b0;
        end else if (cxl_hit) begin
            tag_v <= 1'b0;
            armed <= 1'b1;
        end else if (tag_v) begin
            if (lat != LAT_MAX) lat <= lat + 1'b1;
        end else if (lfsr_low == '0) begin
            armed <= 1'b1;
        end
    end

    AST_TAG_ONLY_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tag_v) |-> $past(iss_valid && !iss_store)); // R1

    AST_CANCEL_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        cxl_hit |=> (armed && !tag_v)); // R6

    AST_LAT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_v && $past(tag_v) && ($past(lat) == LAT_MAX)) |-> (lat == LAT_MAX)); // R9

endmodule

// File: rtl/llsm_capture.sv
// Module: qualifies retired tagged loads, counts them and answers assist requests.
// Assumes: ret_hit marks the retire of the tagged load, with its latency on ret_lat.
module llsm_capture
    import llsm_pkg::*;
#(
    parameter int LAT_W = 16,
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ret_hit,
    input  logic [LAT_W-1:0]      ret_lat,
    input  logic [LAT_W-1:0]      thr,
    input  ld_attr_t              ret_attr,
    input  logic                  asst_req,
    output logic                  asst_ack,
    output logic [LAT_W-1:0]      asst_lat,
    output logic [SRC_WORD_W-1:0] asst_src,
    output logic [CNT_W-1:0]      qual_count
);

    logic [LAT_W-1:0] cap_lat;
    ld_attr_t         cap_attr;
    ld_attr_t         out_attr;
    logic             qualify;

    // Strictly-greater comparison against the threshold.
    always_comb qualify = ret_hit && (ret_lat > thr);

    // Keep the latest qualifying load and count it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_lat    <= '0;
            cap_attr   <= '0;
            qual_count <= '0;
        end else if (qualify) begin
            cap_lat    <= ret_lat;
            cap_attr   <= ret_attr;
            qual_count <= qual_count + 1'b1;
        end
    end

    // Answer an assist one cycle later with the values held before the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asst_ack <= 1'b0;
            asst_lat <= '0;
            out_attr <= '0;
        end else begin
            asst_ack <= asst_req;
            if (asst_req) begin
                asst_lat <= cap_lat;
                out_attr <= cap_attr;
            end
        end
    end

    // Widen the packed attributes to the record word.
    always_comb asst_src = pack_src(out_attr);

    AST_COUNT_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_count != $past(qual_count)) |-> $past(ret_lat > thr)); // R2

    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        asst_ack |-> $past(asst_req)); // R7

    AST_ANSWER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(asst_req) |-> $stable(asst_lat)); // R7

endmodule

// File: rtl/load_latency_sampler.sv
// Module: top of the load latency sampling monitor.
// It connects the configuration registers, the LFSR pacing, the tag tracker and the capture/assist stage.
// Assumes: a single clock domain with synchronous active-low reset.
module load_latency_sampler
    import llsm_pkg::*;
#(
    parameter int ID_W     = 6,
    parameter int LAT_W    = 16,
    parameter int CNT_W    = 32,
    parameter int THR_MIN  = 3,
    parameter int LFSR_W   = 16,
    parameter int SEL_BITS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  iss_valid,
    input  logic                  iss_store,
    input  logic [ID_W-1:0]       iss_id,
    input  logic                  ret_valid,
    input  logic                  ret_store,
    input  logic [ID_W-1:0]       ret_id,
    input  logic [3:0]            ret_src,
    input  logic                  ret_stlb_miss,
    input  logic                  ret_locked,
    input  logic                  cxl_valid,
    input  logic [ID_W-1:0]       cxl_id,
    input  logic                  cfg_we,
    input  logic                  cfg_sel,
    input  logic [63:0]           cfg_wdata,
    input  logic                  asst_req,
    output logic                  asst_ack,
    output logic [LAT_W-1:0]      asst_lat,
    output logic [SRC_WORD_W-1:0] asst_src,
    output logic [CNT_W-1:0]      qual_count
);

    logic [LAT_W-1:0]  thr;
    logic              en;
    logic [LFSR_W-1:0] lfsr;
    logic              ret_hit;
    logic [LAT_W-1:0]  ret_lat;
    ld_attr_t          ret_attr;

    // Gather the retiring load's attributes.
    always_comb begin
        ret_attr.src       = ret_src;
        ret_attr.stlb_miss = ret_stlb_miss;
        ret_attr.locked    = ret_locked;
    end

    llsm_cfg #(
        .LAT_W  (LAT_W),
        .DATA_W (64),
        .THR_MIN(THR_MIN)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .thr      (thr),
        .en       (en)
    );

    llsm_lfsr #(
        .W(LFSR_W)
    ) u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .state(lfsr)
    );

    llsm_tag_tracker #(
        .ID_W    (ID_W),
        .LAT_W   (LAT_W),
        .SEL_BITS(SEL_BITS)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .lfsr_low (lfsr[SEL_BITS-1:0]),
        .iss_valid(iss_valid),
        .iss_store(iss_store),
        .iss_id   (iss_id),
        .ret_valid(ret_valid),
        .ret_store(ret_store),
        .ret_id   (ret_id),
        .cxl_valid(cxl_valid),
        .cxl_id   (cxl_id),
        .ret_hit  (ret_hit),
        .ret_lat  (ret_lat)
    );

    llsm_capture #(
        .LAT_W(LAT_W),
        .CNT_W(CNT_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .ret_hit   (ret_hit),
        .ret_lat   (ret_lat),
        .thr       (thr),
        .ret_attr  (ret_attr),
        .asst_req  (asst_req),
        .asst_ack  (asst_ack),
        .asst_lat  (asst_lat),
        .asst_src  (asst_src),
        .qual_count(qual_count)
    );

    AST_COUNT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_count != $past(qual_count)) |-> $past(en)); // R4

endmodule

// File: tb/load_latency_sampler_tb.sv
module load_latency_sampler_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 0, iss_store = 0;
    logic [5:0]  iss_id = 0;
    logic        ret_valid = 0, ret_store = 0;
    logic [5:0]  ret_id = 0;
    logic [3:0]  ret_src = 0;
    logic        ret_stlb_miss = 0, ret_locked = 0;
    logic        cxl_valid = 0;
    logic [5:0]  cxl_id = 0;
    logic        cfg_we = 0, cfg_sel = 0;
    logic [63:0] cfg_wdata = 0;
    logic        asst_req = 0;
    logic        asst_ack;
    logic [15:0] asst_lat;
    logic [63:0] asst_src;
    logic [31:0] qual_count;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    string phase = "R10";
    bit done = 0;

    always #5 clk = ~clk;

    load_latency_sampler u_dut (.*);

    // Behavioural reference model.
    logic [15:0] m_lfsr;
    bit m_tag_v, m_armed, m_en0, m_en32, m_ack;
    int m_tag_id, m_lat, m_thr, m_cap_lat, m_olat;
    longint unsigned m_cnt;
    logic [63:0] m_cap_src, m_osrc;

    always @(posedge clk) begin
        bit en, take, rh, ch;
        if (!rst_n) begin
            m_lfsr = 16'hACE1; m_tag_v = 0; m_armed = 0; m_en0 = 0; m_en32 = 0;
            m_ack = 0; m_tag_id = 0; m_lat = 0; m_thr = 3; m_cap_lat = 0;
            m_olat = 0; m_cnt = 0; m_cap_src = 0; m_osrc = 0;
        end else begin
            en   = m_en0 && m_en32;
            take = iss_valid && !iss_store && !m_tag_v && (m_armed || m_lfsr[2:0] == 0);
            rh   = en && m_tag_v && ret_valid && !ret_store && (ret_id == m_tag_id);
            ch   = en && m_tag_v && cxl_valid && (cxl_id == m_tag_id) && !rh;
            m_ack = asst_req;
            if (asst_req) begin m_olat = m_cap_lat; m_osrc = m_cap_src; end
            if (rh && m_lat > m_thr) begin
                m_cap_lat = m_lat;
                m_cap_src = {58'd0, ret_locked, ret_stlb_miss, ret_src};
                m_cnt = (m_cnt + 1) % (64'd1 << 32);
            end
            if (!en) begin m_tag_v = 0; m_armed = 0; end
            else if (take) begin m_tag_v = 1; m_tag_id = iss_id; m_lat = 1; m_armed = 0; end
            else if (rh) m_tag_v = 0;
            else if (ch) begin m_tag_v = 0; m_armed = 1; end
            else if (m_tag_v) begin if (m_lat < 65535) m_lat++; end
            else if (m_lfsr[2:0] == 0) m_armed = 1;
            if (cfg_we) begin
                if (!cfg_sel) m_thr = (cfg_wdata[15:0] < 3) ? 3 : int'(cfg_wdata[15:0]);
                else begin m_en0 = cfg_wdata[0]; m_en32 = cfg_wdata[32]; end
            end
            m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(phase, "asst_ack", asst_ack, m_ack);
            check(phase, "asst_lat", asst_lat, m_olat);
            check(phase, "asst_src", asst_src, m_osrc);
            check(phase, "qual_count", qual_count, m_cnt);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cfg_write(input bit sel, input logic [63:0] d);
        @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    // Request an assist; returns after the answer is visible.
    task automatic assist(output int lat, output logic [63:0] src);
        @(negedge clk); asst_req = 1;
        @(negedge clk); asst_req = 0;
        lat = asst_lat; src = asst_src;
    endtask

    // Issue loads until one is tagged, then retire (mode 0) or cancel (mode 1) it after lat cycles.
    task automatic run_tagged(input int lat, input int mode, input logic [3:0] s, input bit t, input bit l);
        bit got = 0;
        while (!got) begin
            @(negedge clk); iss_valid = 1; iss_store = 0; iss_id = 6'd5;
            @(negedge clk); iss_valid = 0;
            if (!m_tag_v) begin
                ret_valid = 1; ret_id = 6'd5; ret_store = 0;
                @(negedge clk); ret_valid = 0;
            end else begin
                got = 1;
                for (int i = 0; i < lat - 1; i++) @(negedge clk);
                if (mode == 0) begin
                    ret_valid = 1; ret_id = 6'd5; ret_store = 0;
                    ret_src = s; ret_stlb_miss = t; ret_locked = l;
                end else begin
                    cxl_valid = 1; cxl_id = 6'd5;
                end
                @(negedge clk); ret_valid = 0; cxl_valid = 0;
            end
        end
    endtask

    initial begin
        int lat, c0;
        logic [63:0] src;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        check("R10", "reset qual_count", qual_count, 0);
        check("R10", "reset asst_ack", asst_ack, 0);
        check("R10", "reset asst_lat", asst_lat, 0);
        check("R10", "reset asst_src", asst_src, 0);

        // R4: nothing counted while disabled or half enabled
        phase = "R4";
        for (int k = 0; k < 2; k++) begin
            if (k == 1) cfg_write(1, 64'h1);
            for (int j = 0; j < 20; j++) begin
                @(negedge clk); iss_valid = 1; iss_id = 6'(j);
                @(negedge clk); iss_valid = 0; idle(8);
                ret_valid = 1; ret_id = 6'(j);
                @(negedge clk); ret_valid = 0;
            end
            check("R4", "count while not fully enabled", qual_count, 0);
        end
        cfg_write(1, 64'h0000_0001_0000_0001);

        // R3: threshold write of 0 clamps to 3
        phase = "R3";
        cfg_write(0, 64'd0);
        run_tagged(3, 0, 4'h1, 0, 0);
        idle(1);
        check("R3", "latency 3 not counted at floor", qual_count, 0);
        run_tagged(4, 0, 4'h2, 0, 0);
        idle(1);
        check("R3", "latency 4 counted at floor", qual_count, 1);
        assist(lat, src);
        check("R3", "captured latency 4", lat, 4);

        // R2: strictly greater than threshold
        phase = "R2";
        cfg_write(0, 64'd10);
        run_tagged(10, 0, 4'h3, 0, 0);
        idle(1);
        check("R2", "latency equal to threshold ignored", qual_count, 1);
        run_tagged(11, 0, 4'h4, 0, 0);
        idle(1);
        check("R2", "latency above threshold counted", qual_count, 2);

        // R8: source word packing
        phase = "R8";
        cfg_write(0, 64'd3);
        run_tagged(6, 0, 4'hA, 1, 1);
        assist(lat, src);
        check("R8", "source word A/miss/lock", src, 64'h3A);
        check("R9", "captured latency 6", lat, 6);
        run_tagged(7, 0, 4'h5, 0, 1);
        assist(lat, src);
        check("R8", "source word 5/lock", src, 64'h25);

        // R1: stores are never tagged or counted
        phase = "R1";
        c0 = qual_count;
        for (int j = 0; j < 24; j++) begin
            @(negedge clk); iss_valid = 1; iss_store = 1; iss_id = 6'd9;
            @(negedge clk); iss_valid = 0; iss_store = 0; idle(10);
            ret_valid = 1; ret_store = 1; ret_id = 6'd9; ret_src = 4'hF;
            @(negedge clk); ret_valid = 0; ret_store = 0;
        end
        check("R1", "stores leave count", qual_count, c0);
        assist(lat, src);
        check("R1", "stores leave capture", src, 64'h25);

        // R6: cancel is not counted, keeps capture, next load tagged at once
        phase = "R6";
        c0 = qual_count;
        run_tagged(20, 1, 4'h0, 0, 0);
        idle(1);
        check("R6", "cancelled load not counted", qual_count, c0);
        assist(lat, src);
        check("R6", "capture kept after cancel", lat, 7);
        @(negedge clk); iss_valid = 1; iss_id = 6'd12;
        @(negedge clk); iss_valid = 0; idle(19);
        ret_valid = 1; ret_id = 6'd12; ret_src = 4'h6;
        @(negedge clk); ret_valid = 0;
        check("R6", "first load after cancel tagged and counted", qual_count, c0 + 1);

        // R7: assist in the same cycle as a qualifying retire returns the older sample
        phase = "R7";
        begin
            bit got = 0;
            while (!got) begin
                @(negedge clk); iss_valid = 1; iss_id = 6'd7;
                @(negedge clk); iss_valid = 0;
                if (!m_tag_v) begin
                    ret_valid = 1; ret_id = 6'd7; @(negedge clk); ret_valid = 0;
                end else begin
                    got = 1; idle(8);
                    ret_valid = 1; ret_id = 6'd7; ret_src = 4'h9; asst_req = 1;
                    @(negedge clk); ret_valid = 0; asst_req = 0;
                    check("R7", "ack one cycle after request", asst_ack, 1);
                    check("R7", "older latency returned", asst_lat, 20);
                end
            end
        end
        assist(lat, src);
        check("R7", "new sample on next request", lat, 9);

        // R9: saturation at 65535
        phase = "R9";
        cfg_write(0, 64'd100);
        run_tagged(65545, 0, 4'hC, 0, 0);
        assist(lat, src);
        check("R9", "latency saturates", lat, 65535);

        // R5: random traffic against the model
        phase = "R5";
        for (int j = 0; j < 4000; j++) begin
            @(negedge clk);
            iss_valid = ($urandom_range(0, 9) < 4);
            iss_store = ($urandom_range(0, 3) == 0);
            iss_id = 6'($urandom_range(0, 7));
            ret_valid = ($urandom_range(0, 9) < 4);
            ret_store = ($urandom_range(0, 3) == 0);
            ret_id = 6'($urandom_range(0, 7));
            ret_src = 4'($urandom); ret_stlb_miss = 1'($urandom); ret_locked = 1'($urandom);
            cxl_valid = ($urandom_range(0, 19) == 0);
            cxl_id = 6'($urandom_range(0, 7));
            asst_req = ($urandom_range(0, 19) == 0);
            cfg_we = ($urandom_range(0, 99) == 0); cfg_sel = 0;
            cfg_wdata = 64'($urandom_range(0, 12));
        end
        @(negedge clk);
        iss_valid = 0; ret_valid = 0; cxl_valid = 0; asst_req = 0; cfg_we = 0;
        idle(2);
        check("R5", "random traffic count", qual_count, m_cnt);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule